// File: doc/BRIEF.md
# External Interrupt Flag Register

This block keeps one sticky event flag for each external interrupt line and makes all of them visible in a single byte-wide register on a simple CPU bus. Each line has a pin. When the pin moves in the direction chosen by its polarity input, the flag for that line is set. The flag, gated by a per-line enable input, becomes an interrupt request toward the interrupt controller.

Software acknowledges an event by reading the register and then writing 0 to the flag it saw set. Each bit has its own arming qualifier. A read that returns 1 for a bit arms that bit, and only an armed bit can be cleared by a written 0. The qualifier is dropped whenever its flag is set again by a pin edge or is cleared. As a result, a byte write carrying stale copies of the other bits (a read-modify-write, or a bit-clear instruction) can never erase an event that software has not yet seen.

The interrupt logic can also clear a flag directly when it services that line. A pin edge in the same cycle as a clear takes priority, so the flag stays set.

Top module: `irqf_status_reg`

## Requirements
- R1: While reset is high and on the first cycle after it, every flag is 0, so `irq_req_o` and the read data are 0.
- R2: A flag is set one clock after its pin changes in the selected direction: a 0-to-1 change when its `pin_pol_i` bit is 1, and a 1-to-0 change when that bit is 0. A change in the other direction leaves the flag unchanged.
- R3: During a read (`bus_sel_i`=1, `bus_wr_i`=0), bit i of `bus_rdata_o` is the flag of line i, and unused upper bits are 0. At any other time `bus_rdata_o` is 0.
- R4: Writing 0 to a bit that was armed by an earlier read returning 1 for that bit clears its flag on the next clock.
- R5: Writing 0 to a bit that was not armed leaves its flag set. This holds in particular for a flag that was set after the last read.
- R6: Writing 1 to a flag bit has no effect on the flag and does not change its arming.
- R7: A 1 on `svc_clr_i[i]` clears flag i on the next clock whether or not it is armed. The bit then stays unarmed, so after a later pin edge a write of 0 alone does not clear it.
- R8: If a pin edge and a clear (from software or from service) hit the same flag in the same cycle, the flag ends set and unarmed.
- R9: A pin edge on a flag that is already set disarms it. A later write of 0 without a new read leaves the flag set.
- R10: `irq_req_o[i]` equals flag i ANDed with `irq_en_i[i]`.
- R11: The pin level seen on the first clock after reset is taken as the baseline. A pin that is already at its active level when reset ends does not set a flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | N_LINES | External interrupt pins, already synchronous to clk |
| pin_pol_i | input | N_LINES | Per-line edge select: 1 = rising, 0 = falling |
| irq_en_i | input | N_LINES | Per-line request enable |
| svc_clr_i | input | N_LINES | Per-line clear pulse from interrupt servicing |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read, while selected |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, zero when not reading |
| irq_req_o | output | N_LINES | Enabled interrupt requests |

## Verification
The critical overlap is a pin edge landing in the same cycle as a clear of the same flag, either an armed software write of 0 or a service pulse. The set must win, and it must leave the bit unarmed. Directed sequences arm a flag, re-raise its pin edge in exactly the write cycle, and then send a second bare write of 0, which must not clear it. Random traffic mixes pin toggles, reads, stale write-backs and service pulses, and a cycle-level reference model built from the rules checks the request and read-data outputs on every cycle.

// File: rtl/irqf_pkg.sv
package irqf_pkg;

    typedef enum logic [1:0] {
        CELL_HOLD  = 2'd0,
        CELL_SET   = 2'd1,
        CELL_CLEAR = 2'd2
    } cell_act_t;

    typedef struct packed {
        logic rd;
        logic wr;
    } bus_op_t;

    function automatic bus_op_t decode_op(logic sel, logic wr);
        bus_op_t op;
        op.rd = sel & ~wr;
        op.wr = sel & wr;
        return op;
    endfunction

    function automatic logic edge_hit(logic primed, logic prev, logic cur, logic pol);
        return primed & (prev != cur) & (cur == pol);
    endfunction

    // A new event always outranks any clear source.
    function automatic cell_act_t resolve_act(logic set, logic hw_clr, logic sw_clr);
        if (set)
            return CELL_SET;
        else if (hw_clr || sw_clr)
            return CELL_CLEAR;
        return CELL_HOLD;
    endfunction

endpackage

// File: rtl/irqf_edge_det.sv
module irqf_edge_det
    import irqf_pkg::*;
#(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] pin_i,
    input  logic [N_LINES-1:0] pol_i,
    output logic [N_LINES-1:0] hit_o
);

    logic [N_LINES-1:0] prev_q;
    logic               primed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= pin_i;
            primed_q <= 1'b1;
        end
    end

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        assign hit_o[g] = edge_hit(primed_q, prev_q[g], pin_i[g], pol_i[g]);
    end

endmodule

// File: rtl/irqf_flag_cell.sv
module irqf_flag_cell
    import irqf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic hw_clr_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o
);

    logic      flag_q;
    logic      armed_q;
    logic      sw_clr;
    cell_act_t act;

    assign sw_clr = wr_i & ~wbit_i & armed_q;
    assign act    = resolve_act(set_i, hw_clr_i, sw_clr);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            unique case (act)
                CELL_SET: begin
                    flag_q  <= 1'b1;
                    armed_q <= 1'b0;
                end
                CELL_CLEAR: begin
                    flag_q  <= 1'b0;
                    armed_q <= 1'b0;
                end
                default: begin
                    if (rd_i && flag_q)
                        armed_q <= 1'b1;
                end
            endcase
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/irqf_status_reg.sv
module irqf_status_reg
    import irqf_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] pin_i,
    input  logic [N_LINES-1:0] pin_pol_i,
    input  logic [N_LINES-1:0] irq_en_i,
    input  logic [N_LINES-1:0] svc_clr_i,
    input  logic               bus_sel_i,
    input  logic               bus_wr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic [N_LINES-1:0] irq_req_o
);

    localparam int FLAG_MSB = N_LINES - 1;

    bus_op_t            op;
    logic [N_LINES-1:0] hit;
    logic [N_LINES-1:0] flag_q;

    assign op = decode_op(bus_sel_i, bus_wr_i);

    irqf_edge_det #(.N_LINES(N_LINES)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .pin_i (pin_i),
        .pol_i (pin_pol_i),
        .hit_o (hit)
    );

    for (genvar g = 0; g < N_LINES; g++) begin : g_cell
        irqf_flag_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .set_i    (hit[g]),
            .hw_clr_i (svc_clr_i[g]),
            .rd_i     (op.rd),
            .wr_i     (op.wr),
            .wbit_i   (bus_wdata_i[g]),
            .flag_o   (flag_q[g])
        );
    end

    always_comb begin
        bus_rdata_o = '0;
        if (op.rd)
            bus_rdata_o[FLAG_MSB:0] = flag_q;
    end

    assign irq_req_o = flag_q & irq_en_i;

endmodule

// File: rtl/irqf_status_reg_chk.sv
module irqf_status_reg_chk #(
    parameter int N_LINES = 8,
    parameter int DATA_W  = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [N_LINES-1:0] pin_i,
    input logic [N_LINES-1:0] pin_pol_i,
    input logic [N_LINES-1:0] irq_en_i,
    input logic [N_LINES-1:0] svc_clr_i,
    input logic               bus_sel_i,
    input logic               bus_wr_i,
    input logic [DATA_W-1:0]  bus_wdata_i,
    input logic [DATA_W-1:0]  bus_rdata_o,
    input logic [N_LINES-1:0] irq_req_o,
    input logic [N_LINES-1:0] flags_i
);

    logic [1:0]         age_q;
    logic [N_LINES-1:0] pin_d1, pin_d2, pol_d1, flag_d1, svc_d1, wclr_d1;
    logic [N_LINES-1:0] edge_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
        pin_d1  <= pin_i;
        pin_d2  <= pin_d1;
        pol_d1  <= pin_pol_i;
        flag_d1 <= flags_i;
        svc_d1  <= svc_clr_i;
        wclr_d1 <= (bus_sel_i && bus_wr_i) ? ~bus_wdata_i[N_LINES-1:0] : '0;
    end

    assign edge_seen = (pin_d1 ^ pin_d2) & ~(pin_d1 ^ pol_d1);

    // R2: a flag only rises after a matching pin edge
    a_r2_set_needs_edge: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2) |-> ((flags_i & ~flag_d1 & ~edge_seen) == '0));

    // R8: a matching edge always leaves the flag set, whatever clears arrive
    a_r8_edge_wins: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2) |-> ((edge_seen & ~flags_i) == '0));

    // R5: a flag only falls after a service pulse or a written 0
    a_r5_clear_needs_cause: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd1) |-> ((flag_d1 & ~flags_i & ~svc_d1 & ~wclr_d1) == '0));

    // R3: read data is quiet outside reads
    a_r3_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel_i && !bus_wr_i) |-> (bus_rdata_o == '0));

    // R10: a disabled line never requests
    a_r10_masked: assert property (@(posedge clk) disable iff (rst)
        ((irq_req_o & ~irq_en_i) == '0));

endmodule

bind irqf_status_reg irqf_status_reg_chk #(
    .N_LINES (N_LINES),
    .DATA_W  (DATA_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pin_i       (pin_i),
    .pin_pol_i   (pin_pol_i),
    .irq_en_i    (irq_en_i),
    .svc_clr_i   (svc_clr_i),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_req_o   (irq_req_o),
    .flags_i     (flag_q)
);

// File: tb/sim_irqf_status_reg.sv
`timescale 1ns/1ps
module sim_irqf_status_reg;

    localparam int NL = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] pin = '0, pol = '1, en = '1, svc = '0;
    logic          sel = 1'b0, wr = 1'b0;
    logic [DW-1:0] wd = '0;
    logic [DW-1:0] rdata;
    logic [NL-1:0] irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [NL-1:0] m_flag = '0, m_arm = '0, m_prev = '0;
    bit            m_primed = 1'b0;

    always #2.5 clk = ~clk;

    irqf_status_reg #(.N_LINES(NL), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .pin_i(pin), .pin_pol_i(pol), .irq_en_i(en),
        .svc_clr_i(svc), .bus_sel_i(sel), .bus_wr_i(wr), .bus_wdata_i(wd),
        .bus_rdata_o(rdata), .irq_req_o(irq)
    );

    task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [NL-1:0] edges_of(logic [NL-1:0] p);
        return m_primed ? ((p ^ m_prev) & ~(p ^ pol)) : '0;
    endfunction

    // one clock: drive at negedge, check read data, advance model, check requests
    task automatic step(input logic [NL-1:0] p, input logic s, input logic w,
                        input logic [DW-1:0] d, input logic [NL-1:0] c);
        logic [NL-1:0] hit, clr, nf, na;
        @(negedge clk);
        pin = p; sel = s; wr = w; wd = d; svc = c;
        #1;
        chk(rdata, (s && !w && !rst) ? DW'(m_flag) : '0, "R3 read data");
        if (rst) begin
            nf = '0; na = '0;
        end else begin
            hit = edges_of(p);
            clr = c | ((s && w) ? (~d[NL-1:0] & m_arm) : '0);
            nf  = hit | (m_flag & ~clr);
            na  = ~hit & ~clr & (m_arm | ((s && !w) ? m_flag : '0));
        end
        @(posedge clk);
        #1;
        m_flag = nf; m_arm = na;
        m_prev = rst ? '0 : p;
        m_primed = !rst;
        chk(DW'(irq), DW'(m_flag & en), "R10 request");
    endtask

    task automatic expect_flags(input logic [NL-1:0] exp, input string tag);
        chk(DW'(irq), DW'(exp & en), tag);
    endtask

    initial begin
        logic [NL-1:0] p;
        void'($urandom(32'h5a17));
        pin = 8'hFF;
        for (int i = 0; i < 3; i++) step(8'hFF, 1'b1, 1'b0, '0, '0);
        expect_flags(8'h00, "R1 flags in reset");
        rst = 1'b0;
        step(8'hFF, 1'b1, 1'b0, '0, '0);
        expect_flags(8'h00, "R11 baseline pin level");
        step(8'hFF, 1'b1, 1'b0, '0, '0);
        chk(rdata, 8'h00, "R1 read after reset");
        step(8'h00, 1'b0, 1'b0, '0, '0);
        expect_flags(8'h00, "R2 opposite edge ignored");
        step(8'h01, 1'b0, 1'b0, '0, '0);
        expect_flags(8'h01, "R2 rising edge sets");
        pol = 8'hFD;
        step(8'h03, 1'b0, 1'b0, '0, '0);
        expect_flags(8'h01, "R2 rising ignored on falling line");
        step(8'h01, 1'b0, 1'b0, '0, '0);
        expect_flags(8'h03, "R2 falling edge sets");
        step(8'h01, 1'b1, 1'b1, 8'h00, '0);
        expect_flags(8'h03, "R5 unarmed write of 0");
        step(8'h01, 1'b1, 1'b0, '0, '0);
        step(8'h05, 1'b0, 1'b0, '0, '0);
        expect_flags(8'h07, "R2 new flag after read");
        step(8'h05, 1'b1, 1'b1, 8'h00, '0);
        expect_flags(8'h04, "R5 stale write-back keeps unseen flag");
        step(8'h05, 1'b1, 1'b0, '0, '0);
        step(8'h05, 1'b1, 1'b1, 8'hFF, '0);
        expect_flags(8'h04, "R6 write of 1 ignored");
        step(8'h05, 1'b1, 1'b1, 8'h00, '0);
        expect_flags(8'h00, "R4 armed write of 0 clears");
        step(8'h0D, 1'b0, 1'b0, '0, '0);
        step(8'h0D, 1'b1, 1'b0, '0, '0);
        step(8'h05, 1'b0, 1'b0, '0, '0);
        step(8'h0D, 1'b1, 1'b1, 8'h00, '0);
        expect_flags(8'h08, "R8 edge beats software clear");
        step(8'h0D, 1'b1, 1'b1, 8'h00, '0);
        expect_flags(8'h08, "R8 flag left unarmed");
        step(8'h0D, 1'b1, 1'b0, '0, '0);
        step(8'h05, 1'b0, 1'b0, '0, '0);
        step(8'h0D, 1'b0, 1'b0, '0, '0);
        step(8'h0D, 1'b1, 1'b1, 8'h00, '0);
        expect_flags(8'h08, "R9 re-edge disarms");
        step(8'h0D, 1'b1, 1'b0, '0, '0);
        step(8'h0D, 1'b1, 1'b1, 8'h00, '0);
        expect_flags(8'h00, "R4 clear after fresh read");
        step(8'h1D, 1'b1, 1'b0, '0, '0);
        step(8'h1D, 1'b0, 1'b0, '0, 8'h10);
        expect_flags(8'h00, "R7 service clear");
        step(8'h0D, 1'b0, 1'b0, '0, '0);
        step(8'h1D, 1'b0, 1'b0, '0, '0);
        step(8'h1D, 1'b1, 1'b1, 8'h00, '0);
        expect_flags(8'h10, "R7 stays unarmed after service");
        step(8'h0D, 1'b0, 1'b0, '0, '0);
        step(8'h1D, 1'b0, 1'b0, '0, 8'h10);
        expect_flags(8'h10, "R8 edge beats service clear");
        en = 8'h00;
        step(8'h1D, 1'b0, 1'b0, '0, '0);
        chk(DW'(irq), 8'h00, "R10 all disabled");
        en = 8'h10;
        step(8'h1D, 1'b0, 1'b0, '0, '0);
        chk(DW'(irq), 8'h10, "R10 enabled line");
        en = '1;
        p = 8'h1D;
        for (int i = 0; i < 4000; i++) begin
            p = p ^ NL'($urandom & $urandom & $urandom);
            if ($urandom % 64 == 0) pol = NL'($urandom);
            if ($urandom % 32 == 0) en = NL'($urandom);
            step(p, ($urandom % 3) != 0, $urandom % 2 == 1,
                 ($urandom % 2 == 1) ? DW'($urandom & $urandom) : '0,
                 ($urandom % 8 == 0) ? NL'($urandom & $urandom) : '0);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule